// File: doc/BRIEF.md
# Trap Dispatch and Vector Generator

When a trap is raised, this block decides which execution mode will handle it and where the handler starts. It takes a snapshot of the processor's trap context: the current trap depth, the error-recovery flag, the hypervisor flag, the supervisor flag, the trap code and the two table bases, one for the supervisor and one for the hypervisor. From these it picks one of four outcomes:

- error-recovery entry
- hypervisor entry
- supervisor entry
- a fatal nesting error

It reports the trap code actually used for vectoring and a flag that tells the state-save unit whether the target mode is the hypervisor. It also produces the handler's program counter and the next two sequential fetch addresses.

The decision and address logic is purely combinational. A parameter adds one output register stage, which is present by default. The unit that saves state consumes the outputs on the cycle that the valid flag is high.

Top module: `trap_vector_unit`

## Requirements
- R1: The current mode is hypervisor when `hprivBit` is set, otherwise supervisor when `privBit` is set, otherwise user. A trap from user or supervisor mode targets supervisor mode, and a trap from hypervisor mode targets hypervisor mode.
- R2: When `redBit` is set or `curTl` equals MAX_TL-1, the path is error-recovery (`pathSel`=0). In that case `vecType`=5, `toHyp`=1, and `newPc` = 0xFFF0000000 OR ((5<<5) AND 0xFF) = 0xFFF00000A0.
- R3: When R2 does not apply and `curTl` equals MAX_TL, the outputs are the following. `errFlag`=1 and `pathSel`=3. `newPc`, `newNpc`, `newNnpc`, `vecType` and `toHyp` are all zero.
- R4: When no earlier rule applies, `curTl` > MAX_PTL and the target is supervisor, the trap is redirected to the hypervisor (`pathSel`=1, `toHyp`=1). It uses `vecType`=2 and `newPc` = (hypBase with bits 13:0 cleared) OR 0x40.
- R5: When no earlier rule applies and either the target is hypervisor or `trapType` >= 384, the path is hypervisor (`pathSel`=1, `toHyp`=1, `vecType`=`trapType`). `newPc` = (hypBase with bits 13:0 cleared) OR ((trapType<<5) AND 0x3FFF).
- R6: All other traps take the supervisor path (`pathSel`=2, `toHyp`=0, `vecType`=`trapType`). `newPc` = (privBase with bits 14:0 cleared) OR (bit 14 set when `curTl`+1 > 1) OR (trapType<<5).
- R7: For every non-error result, `newNpc` = `newPc`+4 and `newNnpc` = `newPc`+8.
- R8: The rules are tried in the order R2, R3, R4, R5, R6, and the first rule that matches decides the result.
- R9: With the output register on, `outValid` rises one clock after `trapValid` is sampled high, and the results belong to that sample. When `outValid` is low, all result outputs are zero, including right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trapValid | input | 1 | A trap snapshot is present this cycle |
| curTl | input | TL_W | Current trap depth |
| redBit | input | 1 | Error-recovery state flag |
| hprivBit | input | 1 | Hypervisor mode flag |
| privBit | input | 1 | Supervisor mode flag |
| trapType | input | TT_W | Trap code raised |
| privBase | input | ADDR_W | Supervisor trap table base |
| hypBase | input | ADDR_W | Hypervisor trap table base |
| outValid | output | 1 | Results valid |
| pathSel | output | 2 | 0 recovery, 1 hypervisor, 2 supervisor, 3 error |
| vecType | output | TT_W | Trap code used for vectoring |
| toHyp | output | 1 | Target mode is hypervisor |
| errFlag | output | 1 | Nesting limit reached, no vector |
| newPc | output | ADDR_W | Handler address |
| newNpc | output | ADDR_W | Handler address + 4 |
| newNnpc | output | ADDR_W | Handler address + 8 |

## Verification
Every result field passes through exactly one register, so a snapshot applied before a rising edge shows up on all outputs right after that edge. The bench drives each snapshot half a cycle before the edge and samples half a cycle after it. Idle cycles are checked the same way, one edge after `trapValid` drops. Because all fields are sampled in that single window, a path decision and its address can never be compared across different snapshots.

// File: rtl/trap_vec_pkg.sv
package trap_vec_pkg;

  typedef enum logic [1:0] {
    PATH_RED  = 2'd0,
    PATH_HYP  = 2'd1,
    PATH_PRIV = 2'd2,
    PATH_ERR  = 2'd3
  } path_e;

  typedef enum logic [1:0] {
    LVL_USER = 2'd0,
    LVL_PRIV = 2'd1,
    LVL_HYP  = 2'd2
  } level_e;

  // strobes from the control to the datapath, exactly one set
  typedef struct packed {
    logic goRed;
    logic goErr;
    logic goWdog;
    logic goHyp;
    logic goPriv;
  } strobe_t;

  localparam int unsigned RED_TT   = 5;
  localparam int unsigned WDOG_TT  = 2;
  localparam int unsigned SLOT_SH  = 5;

endpackage

// File: rtl/trap_dispatch_ctrl.sv
module trap_dispatch_ctrl
  import trap_vec_pkg::*;
#(
  parameter int TL_W       = 3,
  parameter int TT_W       = 9,
  parameter int MAX_TL     = 6,
  parameter int MAX_PTL    = 2,
  parameter int HYP_TT_MIN = 384
) (
  input  logic [TL_W-1:0] curTl,
  input  logic            redBit,
  input  logic            hprivBit,
  input  logic            privBit,
  input  logic [TT_W-1:0] trapType,
  output strobe_t         strobe,
  output logic [TT_W-1:0] useType
);

  localparam logic [TL_W-1:0] TL_TOP  = TL_W'(MAX_TL);
  localparam logic [TL_W-1:0] TL_RED  = TL_W'(MAX_TL - 1);
  localparam logic [TL_W-1:0] TL_PTOP = TL_W'(MAX_PTL);
  localparam logic [TT_W-1:0] TT_HMIN = TT_W'(HYP_TT_MIN);

  level_e curLevel;
  logic   nextHyp;

  always_comb begin
    if (hprivBit)     curLevel = LVL_HYP;
    else if (privBit) curLevel = LVL_PRIV;
    else              curLevel = LVL_USER;
  end

  assign nextHyp = (curLevel == LVL_HYP);

  always_comb begin
    strobe  = '0;
    useType = trapType;
    if (redBit || curTl == TL_RED) begin
      strobe.goRed = 1'b1;
      useType      = TT_W'(RED_TT);
    end else if (curTl == TL_TOP) begin
      strobe.goErr = 1'b1;
      useType      = '0;
    end else if (curTl > TL_PTOP && !nextHyp) begin
      strobe.goWdog = 1'b1;
      useType       = TT_W'(WDOG_TT);
    end else if (nextHyp || trapType >= TT_HMIN) begin
      strobe.goHyp = 1'b1;
    end else begin
      strobe.goPriv = 1'b1;
    end
  end

endmodule

// File: rtl/trap_vector_dp.sv
module trap_vector_dp
  import trap_vec_pkg::*;
#(
  parameter int          ADDR_W     = 64,
  parameter int          TL_W       = 3,
  parameter int          TT_W       = 9,
  parameter int          INST_BYTES = 4,
  parameter int          HYP_BITS   = 14,
  parameter logic [63:0] RED_BASE   = 64'h0000_00FF_F000_0000,
  parameter bit          REG_OUT    = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trapValid,
  input  logic [TL_W-1:0]   curTl,
  input  logic [ADDR_W-1:0] privBase,
  input  logic [ADDR_W-1:0] hypBase,
  input  strobe_t           strobe,
  input  logic [TT_W-1:0]   useType,
  output logic              outValid,
  output logic [1:0]        pathSel,
  output logic [TT_W-1:0]   vecType,
  output logic              toHyp,
  output logic              errFlag,
  output logic [ADDR_W-1:0] newPc,
  output logic [ADDR_W-1:0] newNpc,
  output logic [ADDR_W-1:0] newNnpc
);

  localparam logic [ADDR_W-1:0] HYP_MASK  = (ADDR_W'(1) << HYP_BITS) - 1;
  localparam logic [ADDR_W-1:0] PRIV_MASK = (ADDR_W'(1) << (HYP_BITS + 1)) - 1;
  localparam logic [ADDR_W-1:0] RED_MASK  = ADDR_W'(8'hFF);
  localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(INST_BYTES);

  logic [ADDR_W-1:0] slot, pcComb;
  logic [1:0]        pathComb;
  logic              hypComb, validComb;

  assign slot = ADDR_W'(useType) << SLOT_SH;

  always_comb begin
    pcComb   = '0;
    pathComb = PATH_PRIV;
    hypComb  = 1'b0;
    if (strobe.goRed) begin
      pcComb   = ADDR_W'(RED_BASE) | (slot & RED_MASK);
      pathComb = PATH_RED;
      hypComb  = 1'b1;
    end else if (strobe.goErr) begin
      pathComb = PATH_ERR;
    end else if (strobe.goWdog || strobe.goHyp) begin
      pcComb   = (hypBase & ~HYP_MASK) | (slot & HYP_MASK);
      pathComb = PATH_HYP;
      hypComb  = 1'b1;
    end else begin
      pcComb = (privBase & ~PRIV_MASK) | (slot & HYP_MASK)
             | ((curTl != '0) ? (ADDR_W'(1) << HYP_BITS) : '0);
    end
  end

  assign validComb = trapValid;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          outValid <= 1'b0;
          pathSel  <= '0;
          vecType  <= '0;
          toHyp    <= 1'b0;
          errFlag  <= 1'b0;
          newPc    <= '0;
          newNpc   <= '0;
          newNnpc  <= '0;
        end else if (validComb) begin
          outValid <= 1'b1;
          pathSel  <= pathComb;
          vecType  <= useType;
          toHyp    <= hypComb;
          errFlag  <= strobe.goErr;
          newPc    <= pcComb;
          newNpc   <= strobe.goErr ? '0 : pcComb + STEP;
          newNnpc  <= strobe.goErr ? '0 : pcComb + (STEP << 1);
        end else begin
          outValid <= 1'b0;
          pathSel  <= '0;
          vecType  <= '0;
          toHyp    <= 1'b0;
          errFlag  <= 1'b0;
          newPc    <= '0;
          newNpc   <= '0;
          newNnpc  <= '0;
        end
      end
    end else begin : g_comb
      logic unusedClk;
      assign unusedClk = clk ^ rstN;
      assign outValid  = validComb;
      assign pathSel   = validComb ? pathComb : '0;
      assign vecType   = validComb ? useType : '0;
      assign toHyp     = validComb & hypComb;
      assign errFlag   = validComb & strobe.goErr;
      assign newPc     = validComb ? pcComb : '0;
      assign newNpc    = (validComb && !strobe.goErr) ? pcComb + STEP : '0;
      assign newNnpc   = (validComb && !strobe.goErr) ? pcComb + (STEP << 1) : '0;
    end
  endgenerate

endmodule

// File: rtl/trap_vector_unit.sv
module trap_vector_unit
  import trap_vec_pkg::*;
#(
  parameter int          ADDR_W     = 64,
  parameter int          TL_W       = 3,
  parameter int          TT_W       = 9,
  parameter int          MAX_TL     = 6,
  parameter int          MAX_PTL    = 2,
  parameter int          HYP_TT_MIN = 384,
  parameter int          INST_BYTES = 4,
  parameter int          HYP_BITS   = 14,
  parameter logic [63:0] RED_BASE   = 64'h0000_00FF_F000_0000,
  parameter bit          REG_OUT    = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trapValid,
  input  logic [TL_W-1:0]   curTl,
  input  logic              redBit,
  input  logic              hprivBit,
  input  logic              privBit,
  input  logic [TT_W-1:0]   trapType,
  input  logic [ADDR_W-1:0] privBase,
  input  logic [ADDR_W-1:0] hypBase,
  output logic              outValid,
  output logic [1:0]        pathSel,
  output logic [TT_W-1:0]   vecType,
  output logic              toHyp,
  output logic              errFlag,
  output logic [ADDR_W-1:0] newPc,
  output logic [ADDR_W-1:0] newNpc,
  output logic [ADDR_W-1:0] newNnpc
);

  strobe_t         strobe;
  logic [TT_W-1:0] useType;

  trap_dispatch_ctrl #(
    .TL_W(TL_W), .TT_W(TT_W), .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL),
    .HYP_TT_MIN(HYP_TT_MIN)
  ) ctrl_i (
    .curTl(curTl), .redBit(redBit), .hprivBit(hprivBit), .privBit(privBit),
    .trapType(trapType), .strobe(strobe), .useType(useType)
  );

  trap_vector_dp #(
    .ADDR_W(ADDR_W), .TL_W(TL_W), .TT_W(TT_W), .INST_BYTES(INST_BYTES),
    .HYP_BITS(HYP_BITS), .RED_BASE(RED_BASE), .REG_OUT(REG_OUT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .trapValid(trapValid), .curTl(curTl),
    .privBase(privBase), .hypBase(hypBase), .strobe(strobe), .useType(useType),
    .outValid(outValid), .pathSel(pathSel), .vecType(vecType), .toHyp(toHyp),
    .errFlag(errFlag), .newPc(newPc), .newNpc(newNpc), .newNnpc(newNnpc)
  );

endmodule

// File: rtl/trap_vector_unit_chk.sv
module trap_vector_unit_chk #(
  parameter int ADDR_W     = 64,
  parameter int TT_W       = 9,
  parameter int INST_BYTES = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              outValid,
  input logic [1:0]        pathSel,
  input logic [TT_W-1:0]   vecType,
  input logic              toHyp,
  input logic              errFlag,
  input logic [ADDR_W-1:0] newPc,
  input logic [ADDR_W-1:0] newNpc,
  input logic [ADDR_W-1:0] newNnpc
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

  a_r2_red_uses_type5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && pathSel == 2'd0) |-> (vecType == TT_W'(5) && toHyp && !errFlag));

  a_r3_error_no_vector: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && errFlag) |-> (pathSel == 2'd3 && newPc == '0 && newNpc == '0 && !toHyp));

  a_r5_hyp_targets_hyp: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && pathSel == 2'd1) |-> (toHyp && !errFlag));

  a_r6_priv_not_hyp: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && pathSel == 2'd2) |-> (!toHyp && newPc[4:0] == 5'd0));

  a_r7_sequential_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !errFlag) |-> (newNpc == newPc + STEP && newNnpc == newPc + (STEP << 1)));

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (newPc == '0 && pathSel == 2'd0 && !errFlag && !toHyp));

endmodule

bind trap_vector_unit trap_vector_unit_chk #(
  .ADDR_W(ADDR_W), .TT_W(TT_W), .INST_BYTES(INST_BYTES)
) chk_i (
  .clk(clk), .rstN(rstN), .outValid(outValid), .pathSel(pathSel),
  .vecType(vecType), .toHyp(toHyp), .errFlag(errFlag), .newPc(newPc),
  .newNpc(newNpc), .newNnpc(newNnpc)
);

// File: tb/trap_vector_unit_tb_top.sv
`timescale 1ns/1ps
module trap_vector_unit_tb_top;

  localparam logic [63:0] TBA  = 64'h0000_1234_5678_9ABC;
  localparam logic [63:0] HTBA = 64'h0000_0ABC_DEF0_1357;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trapValid = 1'b0;
  logic [2:0]  curTl = '0;
  logic        redBit = 1'b0, hprivBit = 1'b0, privBit = 1'b0;
  logic [8:0]  trapType = '0;
  logic [63:0] privBase = TBA, hypBase = HTBA;
  logic        outValid, toHyp, errFlag;
  logic [1:0]  pathSel;
  logic [8:0]  vecType;
  logic [63:0] newPc, newNpc, newNnpc;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trap_vector_unit dut_i (
    .clk(clk), .rstN(rstN), .trapValid(trapValid), .curTl(curTl),
    .redBit(redBit), .hprivBit(hprivBit), .privBit(privBit),
    .trapType(trapType), .privBase(privBase), .hypBase(hypBase),
    .outValid(outValid), .pathSel(pathSel), .vecType(vecType), .toHyp(toHyp),
    .errFlag(errFlag), .newPc(newPc), .newNpc(newNpc), .newNnpc(newNnpc)
  );

  typedef struct packed {
    logic [2:0] tl;
    logic       red;
    logic       hpriv;
    logic       priv;
    logic [8:0] tt;
    logic [1:0] path;
    logic [8:0] typ;
    logic       hyp;
  } tv_t;

  // path codes: 0 recovery, 1 hypervisor, 2 supervisor, 3 error
  localparam int NV = 14;
  localparam tv_t VEC [NV] = '{
    '{3'd0, 1'b0, 1'b0, 1'b0, 9'h010, 2'd2, 9'h010, 1'b0}, // R6 user tl0
    '{3'd1, 1'b0, 1'b0, 1'b1, 9'h024, 2'd2, 9'h024, 1'b0}, // R6 bit14
    '{3'd2, 1'b0, 1'b0, 1'b0, 9'h17F, 2'd2, 9'h17F, 1'b0}, // R6 tt 383
    '{3'd1, 1'b0, 1'b0, 1'b1, 9'h180, 2'd1, 9'h180, 1'b1}, // R5 tt 384
    '{3'd0, 1'b0, 1'b1, 1'b0, 9'h010, 2'd1, 9'h010, 1'b1}, // R1 R5 from hyp
    '{3'd3, 1'b0, 1'b0, 1'b0, 9'h030, 2'd1, 9'h002, 1'b1}, // R4 watchdog
    '{3'd4, 1'b0, 1'b1, 1'b0, 9'h030, 2'd1, 9'h030, 1'b1}, // R1 R8 hyp no wdog
    '{3'd5, 1'b0, 1'b0, 1'b1, 9'h030, 2'd0, 9'h005, 1'b1}, // R2 tl=max-1
    '{3'd1, 1'b1, 1'b0, 1'b0, 9'h030, 2'd0, 9'h005, 1'b1}, // R2 red bit
    '{3'd6, 1'b0, 1'b0, 1'b0, 9'h030, 2'd3, 9'h000, 1'b0}, // R3 error
    '{3'd6, 1'b1, 1'b0, 1'b0, 9'h030, 2'd0, 9'h005, 1'b1}, // R8 red beats error
    '{3'd7, 1'b0, 1'b0, 1'b1, 9'h044, 2'd1, 9'h002, 1'b1}, // R4 tl beyond max
    '{3'd2, 1'b0, 1'b0, 1'b1, 9'h1FF, 2'd1, 9'h1FF, 1'b1}, // R5 tt max
    '{3'd6, 1'b0, 1'b1, 1'b0, 9'h030, 2'd3, 9'h000, 1'b0}  // R8 error beats hyp
  };

  function automatic logic [63:0] expPc(tv_t v);
    logic [63:0] s;
    s = 64'(v.typ) << 5;
    case (v.path)
      2'd0: return 64'hFF_F000_0000 | (s & 64'hFF);
      2'd1: return (HTBA & ~64'h3FFF) | (s & 64'h3FFF);
      2'd2: return (TBA & ~64'h7FFF) | ((v.tl != 0) ? 64'h4000 : 64'h0) | s;
      default: return 64'h0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(outValid == 0 && newPc == 0 && pathSel == 0 && errFlag == 0,
          "R9 reset", {63'd0, outValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      tv_t v = VEC[i];
      logic [63:0] pc;
      pc = expPc(v);
      curTl = v.tl; redBit = v.red; hprivBit = v.hpriv; privBit = v.priv;
      trapType = v.tt; trapValid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check(outValid && pathSel == v.path && vecType == v.typ && toHyp == v.hyp
            && errFlag == (v.path == 2'd3),
            $sformatf("R8 vec%0d path/type", i),
            {51'd0, outValid, pathSel, vecType, toHyp},
            {51'd0, 1'b1, v.path, v.typ, v.hyp});
      check(newPc == pc, $sformatf("R2-6 vec%0d pc", i), newPc, pc);
      if (v.path == 2'd3)
        check(newNpc == 0 && newNnpc == 0, "R3 no vector", newNpc, 64'd0);
      else
        check(newNpc == pc + 4 && newNnpc == pc + 8, "R7 fetch seq", newNnpc, pc + 8);
    end
    // R9 idle: snapshot with valid low leaves outputs zero one edge later
    trapValid = 1'b0; redBit = 1'b1; curTl = 3'd1;
    @(posedge clk);
    @(negedge clk);
    check(outValid == 0 && newPc == 0 && vecType == 0, "R9 idle zero",
          newPc, 64'd0);
    // R9 latency: result tracks snapshot of exactly one edge earlier
    redBit = 1'b0; hprivBit = 1'b0; privBit = 1'b0; curTl = 3'd0;
    trapType = 9'h010; trapValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    trapValid = 1'b0;
    check(outValid == 1 && newPc == ((TBA & ~64'h7FFF) | 64'h200),
          "R9 one-cycle result", newPc, (TBA & ~64'h7FFF) | 64'h200);
    @(posedge clk);
    @(negedge clk);
    check(outValid == 0, "R9 valid drops", {63'd0, outValid}, 64'd0);
    // R1 supervisor from supervisor at tl3 is watchdog, hyp at tl3 is not
    privBit = 1'b1; curTl = 3'd3; trapType = 9'h020; trapValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(vecType == 9'h002 && pathSel == 2'd1, "R1 R4 priv->wdog",
          {55'd0, vecType}, 64'd2);
    trapValid = 1'b0;
    @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule